// File: doc/BRIEF.md
# Write Burst Master Engine

This block is the write side of a memory-mapped bus master. Software or a sequencing unit first fills a small beat store (one data word and one idle-gap count per beat), then presents a single write command: transaction ID, start address, the index of the final beat (beats minus one, 1 to 16 beats) and an idle gap to wait before the address phase. The engine runs the address phase, then streams every beat on the write data channel, each beat preceded by its own idle gap. It then waits for the write response.

Only one burst is in flight at any time. A response counts as finished only in the cycle where the slave's valid and the engine's ready are both high. At that point the response ID and the 2-bit response code are captured and reported once on a one-cycle report strobe. At the same moment the command port opens again for the next burst. Read channels, burst types, transfer size and interleaved IDs are not part of this block.

Top module: `axi_wr_burst_master`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `awvalid`, `wvalid`, `bready` and `rsp_valid` are 0 and `cmd_ready` is 1. Asserting `rst_n` in the middle of a burst returns the engine to this state.
- R2: During a burst, `awid` and `wid` equal the command ID, `awaddr` equals the command address, and `awlen` equals the command's final-beat index (number of beats minus one, so 14 beats give 4'b1101).
- R3: A command is accepted at a rising edge where `cmd_valid` and `cmd_ready` are both high. After a command with address gap G is accepted, `awvalid` is low for exactly G cycles and then rises. With G = 0 it is high in the first cycle after the accepting edge.
- R4: Once `awvalid` is high, it and the address fields stay unchanged until an edge where `awready` is high. `awvalid` is low in the following cycle.
- R5: `wvalid` stays low until the address handshake has happened. Beat 0 then waits its own gap: `wvalid` is low for that many cycles after the handshake edge and then rises.
- R6: After the edge that completes beat k, `wvalid` is low for exactly the gap stored for beat k+1 and then rises. A gap of 0 gives back-to-back beats.
- R7: The beat data on `wdata` and `wvalid` stay unchanged until an edge where `wready` is high. If `wready` is already high in the cycle `wvalid` rises, the beat completes at that edge.
- R8: `wlast` is 1 on the final beat of the burst and 0 on every other beat.
- R9: `bready` is high only after the final beat has completed and until the response handshake. The cycle after the edge where `bvalid` and `bready` are both high, `rsp_valid` is high for exactly one cycle. In that cycle `rsp_id` holds the captured `bid` and `rsp_code` holds `bresp` (0 OKAY, 1 EXOKAY, 2 SLVERR, 3 DECERR).
- R10: `cmd_ready` is low from the accepting edge until the response is reported. It is high again in the same cycle as the `rsp_valid` strobe.
- R11: Writes to the beat store (`bm_we` with `bm_idx`) while `cmd_ready` is low are ignored. The beats of the running burst keep their stored data.
- R12: A `bvalid` that is high before the final beat completes is not accepted: `bready` stays low until the data phase has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_id | input | ID_W | Transaction ID of the burst |
| cmd_addr | input | ADDR_W | Start address |
| cmd_last_idx | input | LEN_W | Number of beats minus one |
| cmd_gap | input | DLY_W | Idle cycles before the address phase |
| bm_we | input | 1 | Beat store write strobe |
| bm_idx | input | LEN_W | Beat store write index |
| bm_data | input | DATA_W | Data word for the indexed beat |
| bm_gap | input | DLY_W | Idle cycles before the indexed beat |
| awid | output | ID_W | Write address ID |
| awaddr | output | ADDR_W | Write address |
| awlen | output | LEN_W | Burst length minus one |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wid | output | ID_W | Write data ID |
| wdata | output | DATA_W | Write data |
| wlast | output | 1 | Final beat marker |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bid | input | ID_W | Response ID |
| bresp | input | 2 | Response code |
| bvalid | input | 1 | Response valid |
| bready | output | 1 | Response ready |
| rsp_valid | output | 1 | One-cycle completed-response strobe |
| rsp_id | output | ID_W | Captured response ID |
| rsp_code | output | 2 | Captured response code |

## Verification
The bench sweeps every burst length from 1 to 16 beats. It mixes address gaps, per-beat gaps, address stalls and data stalls, and measures the exact cycle each valid rises against the gap arithmetic. An off-by-one gap counter would make a valid rise a cycle early or late. An engine that moves on without the ready would change `wdata` during a stall, and a misplaced final-beat compare would raise `wlast` on the wrong beat. Some bursts hold `bvalid` high from the start; a design that answered it at once would report the response before any data was sent. Some bursts also write the beat store during the burst; an engine that took those writes would send corrupted data on the last beat. A reset in the middle of a stalled address phase checks that the engine returns to idle.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AW_GAP,
    ST_AW,
    ST_W_GAP,
    ST_W,
    ST_B
  } wbm_state_e;
endpackage

// File: rtl/wbm_beat_store.sv
// Per-beat storage: data word plus idle-gap count. One read port feeds the
// beat on the bus, the other looks up the gap of the upcoming beat.
module wbm_beat_store #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DLY_W-1:0]  wr_gap,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  gap_idx,
  output logic [DLY_W-1:0]  gap_out
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [DLY_W-1:0]  gap_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[wr_idx] <= wr_data;
      gap_mem[wr_idx]  <= wr_gap;
    end
  end

  assign rd_data = data_mem[rd_idx];
  assign gap_out = gap_mem[gap_idx];
endmodule

// File: rtl/wbm_gap_timer.sv
// Down counter for idle gaps. Loaded with G, it reports its final gap cycle
// when the count reaches one, so a gap state lasts exactly G cycles.
module wbm_gap_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             dec,
  output logic             last_cycle
);
  logic [DLY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last_cycle = (cnt_q == DLY_W'(1));
endmodule

// File: rtl/wbm_resp_capture.sv
// Registers a completed response and raises a one-cycle report strobe.
module wbm_resp_capture #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [ID_W-1:0] in_id,
  input  logic [1:0]      in_code,
  output logic            out_valid,
  output logic [ID_W-1:0] out_id,
  output logic [1:0]      out_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= take;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_id   <= in_id;
      out_code <= in_code;
    end
  end
endmodule

// File: rtl/axi_wr_burst_master.sv
module axi_wr_burst_master
  import wbm_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_last_idx,
  input  logic [DLY_W-1:0]  cmd_gap,
  input  logic              bm_we,
  input  logic [LEN_W-1:0]  bm_idx,
  input  logic [DATA_W-1:0] bm_data,
  input  logic [DLY_W-1:0]  bm_gap,
  output logic [ID_W-1:0]   awid,
  output logic [ADDR_W-1:0] awaddr,
  output logic [LEN_W-1:0]  awlen,
  output logic              awvalid,
  input  logic              awready,
  output logic [ID_W-1:0]   wid,
  output logic [DATA_W-1:0] wdata,
  output logic              wlast,
  output logic              wvalid,
  input  logic              wready,
  input  logic [ID_W-1:0]   bid,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic [1:0]        rsp_code
);
  wbm_state_e       st_q, st_d;
  logic [LEN_W-1:0] beat_q, beat_d;
  logic [ID_W-1:0]  id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0] len_q;

  logic             accept, aw_hs, w_hs, b_hs, on_last;
  logic [LEN_W-1:0] gap_idx;
  logic [DLY_W-1:0] nxt_gap;
  logic             tmr_load, tmr_dec, tmr_last;
  logic [DLY_W-1:0] tmr_val;

  // Channel decode straight from the state register
  assign cmd_ready = (st_q == ST_IDLE);
  assign awvalid   = (st_q == ST_AW);
  assign wvalid    = (st_q == ST_W);
  assign bready    = (st_q == ST_B);

  assign accept  = cmd_valid && cmd_ready;
  assign aw_hs   = awvalid && awready;
  assign w_hs    = wvalid && wready;
  assign b_hs    = bvalid && bready;
  assign on_last = (beat_q == len_q);

  assign awid   = id_q;
  assign wid    = id_q;
  assign awaddr = addr_q;
  assign awlen  = len_q;
  assign wlast  = on_last;

  // Gap of the beat that follows the current handshake
  assign gap_idx = (st_q == ST_AW) ? '0 : beat_q + 1'b1;

  // Store writes only while idle (R11)
  wbm_beat_store #(
    .IDX_W (LEN_W),
    .DATA_W(DATA_W),
    .DLY_W (DLY_W)
  ) u_store (
    .clk    (clk),
    .wr_en  (bm_we && cmd_ready),
    .wr_idx (bm_idx),
    .wr_data(bm_data),
    .wr_gap (bm_gap),
    .rd_idx (beat_q),
    .rd_data(wdata),
    .gap_idx(gap_idx),
    .gap_out(nxt_gap)
  );

  assign tmr_load = accept || aw_hs || (w_hs && !on_last);
  assign tmr_val  = cmd_ready ? cmd_gap : nxt_gap;
  assign tmr_dec  = (st_q == ST_AW_GAP) || (st_q == ST_W_GAP);

  wbm_gap_timer #(
    .DLY_W(DLY_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tmr_load),
    .load_val  (tmr_val),
    .dec       (tmr_dec),
    .last_cycle(tmr_last)
  );

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          st_d = (cmd_gap == '0) ? ST_AW : ST_AW_GAP;
        end
      end
      ST_AW_GAP: begin
        if (tmr_last) begin
          st_d = ST_AW;
        end
      end
      ST_AW: begin
        if (awready) begin
          beat_d = '0;
          st_d   = (nxt_gap == '0) ? ST_W : ST_W_GAP;
        end
      end
      ST_W_GAP: begin
        if (tmr_last) begin
          st_d = ST_W;
        end
      end
      ST_W: begin
        if (wready) begin
          if (on_last) begin
            st_d = ST_B;
          end else begin
            beat_d = beat_q + 1'b1;
            st_d   = (nxt_gap == '0) ? ST_W : ST_W_GAP;
          end
        end
      end
      ST_B: begin
        if (bvalid) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
    end
  end

  // Command fields, loaded with the accept enable
  always_ff @(posedge clk) begin
    if (accept) begin
      id_q   <= cmd_id;
      addr_q <= cmd_addr;
      len_q  <= cmd_last_idx;
    end
  end

  wbm_resp_capture #(
    .ID_W(ID_W)
  ) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (b_hs),
    .in_id    (bid),
    .in_code  (bresp),
    .out_valid(rsp_valid),
    .out_id   (rsp_id),
    .out_code (rsp_code)
  );
endmodule

module axi_wr_burst_master_sva #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic [ID_W-1:0]   awid,
  input logic [ADDR_W-1:0] awaddr,
  input logic [LEN_W-1:0]  awlen,
  input logic              awvalid,
  input logic              awready,
  input logic [DATA_W-1:0] wdata,
  input logic              wlast,
  input logic              wvalid,
  input logic              wready,
  input logic              bvalid,
  input logic              bready,
  input logic              rsp_valid
);
  a_r4_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awid) && $stable(awlen));

  a_r4_aw_drop: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && awready |=> !awvalid);

  a_r5_no_data_during_addr: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> !wvalid);

  a_r7_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));

  a_r9_report_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && bready |=> rsp_valid);

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r10_ready_with_report: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cmd_ready);

  a_r12_no_early_bready: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid || awvalid) |-> !bready);
endmodule

bind axi_wr_burst_master axi_wr_burst_master_sva #(
  .ID_W  (ID_W),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .LEN_W (LEN_W)
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_ready(cmd_ready),
  .awid     (awid),
  .awaddr   (awaddr),
  .awlen    (awlen),
  .awvalid  (awvalid),
  .awready  (awready),
  .wdata    (wdata),
  .wlast    (wlast),
  .wvalid   (wvalid),
  .wready   (wready),
  .bvalid   (bvalid),
  .bready   (bready),
  .rsp_valid(rsp_valid)
);

// File: tb/tb_axi_wr_burst_master.sv
`timescale 1ns/1ps
module tb_axi_wr_burst_master;
  logic        clk;
  logic        rst_n;
  logic        cmd_valid, cmd_ready;
  logic [3:0]  cmd_id;
  logic [31:0] cmd_addr;
  logic [3:0]  cmd_last_idx;
  logic [7:0]  cmd_gap;
  logic        bm_we;
  logic [3:0]  bm_idx;
  logic [31:0] bm_data;
  logic [7:0]  bm_gap;
  logic [3:0]  awid;
  logic [31:0] awaddr;
  logic [3:0]  awlen;
  logic        awvalid, awready;
  logic [3:0]  wid;
  logic [31:0] wdata;
  logic        wlast, wvalid, wready;
  logic [3:0]  bid;
  logic [1:0]  bresp;
  logic        bvalid, bready;
  logic        rsp_valid;
  logic [3:0]  rsp_id;
  logic [1:0]  rsp_code;

  int total = 0;
  int bad   = 0;

  axi_wr_burst_master dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_id(cmd_id),
    .cmd_addr(cmd_addr), .cmd_last_idx(cmd_last_idx), .cmd_gap(cmd_gap),
    .bm_we(bm_we), .bm_idx(bm_idx), .bm_data(bm_data), .bm_gap(bm_gap),
    .awid(awid), .awaddr(awaddr), .awlen(awlen), .awvalid(awvalid), .awready(awready),
    .wid(wid), .wdata(wdata), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_code(rsp_code)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] beat_word(input int seed, input int k);
    return (32'h9E3779B9 * 32'(k + 1)) + (32'h01010101 * 32'(seed));
  endfunction

  function automatic int beat_gap(input int seed, input int k);
    return (k * 5 + seed) % 4;
  endfunction

  function automatic int beat_stall(input int seed, input int k);
    return (k + 2 * seed) % 3;
  endfunction

  task automatic run_burst(input int seed, input int n, input int agap,
                           input int astall, input int bdly,
                           input bit early_b, input bit poke);
    logic [3:0]  id;
    logic [31:0] addr;
    logic [1:0]  code;
    int aw_wait, hs_t, k, k0, wwait, last_end, rsp_t, b_cnt;
    bit aw_done, b_done, done;
    id   = 4'((seed * 3 + n) % 16);
    addr = 32'h1000_0000 + 32'(seed * 64 + n * 4);
    code = 2'((n + seed) % 4);

    @(negedge clk);
    for (int j = 0; j < n; j++) begin
      bm_we   = 1'b1;
      bm_idx  = 4'(j);
      bm_data = beat_word(seed, j);
      bm_gap  = 8'(beat_gap(seed, j));
      @(negedge clk);
    end
    bm_we = 1'b0;
    chk(cmd_ready == 1'b1, "R10", "cmd_ready before command", 32'(cmd_ready), 32'd1);
    cmd_valid    = 1'b1;
    cmd_id       = id;
    cmd_addr     = addr;
    cmd_last_idx = 4'(n - 1);
    cmd_gap      = 8'(agap);
    @(negedge clk);
    cmd_valid = 1'b0;

    aw_done = 0; b_done = 0; done = 0;
    aw_wait = 0; hs_t = 0; k = 0; wwait = 0; last_end = 0; rsp_t = -1; b_cnt = 0;
    for (int t = 1; t <= 3000 && !done; t++) begin
      k0 = k;
      if (b_done) bvalid = 1'b0;
      // R11: store writes during the burst must be ignored
      if (poke && t == 1) begin
        bm_we = 1'b1; bm_idx = 4'(n - 1); bm_data = ~beat_word(seed, n - 1); bm_gap = 8'd0;
      end
      if (poke && t == 2) bm_we = 1'b0;

      // Data channel
      if (k < n) begin
        if (!aw_done) begin
          chk(wvalid == 1'b0, "R5", "wvalid before address handshake", 32'(wvalid), 32'd0);
          wready = 1'b0;
        end else begin
          int rise;
          rise = last_end + beat_gap(seed, k) + 1;
          chk(wvalid == (t >= rise), (k == 0) ? "R5" : "R6", "wvalid gap timing",
              32'(wvalid), 32'(t >= rise));
          if (wvalid) begin
            chk(wdata == beat_word(seed, k), poke ? "R11" : "R7", "wdata of beat",
                wdata, beat_word(seed, k));
            chk(wlast == (k == n - 1), "R8", "wlast", 32'(wlast), 32'(k == n - 1));
            chk(wid == id, "R2", "wid", 32'(wid), 32'(id));
            if (wwait == beat_stall(seed, k)) begin
              wready = 1'b1;
              last_end = t;
              k++;
              wwait = 0;
            end else begin
              wready = 1'b0;
              wwait++;
            end
          end else begin
            wready = (beat_stall(seed, k) == 0);
          end
        end
      end else begin
        chk(wvalid == 1'b0, "R6", "wvalid after final beat", 32'(wvalid), 32'd0);
        wready = 1'b0;
      end

      // Address channel
      if (!aw_done) begin
        chk(awvalid == (t >= agap + 1), "R3", "awvalid gap timing",
            32'(awvalid), 32'(t >= agap + 1));
        if (awvalid) begin
          chk(awid == id, "R2", "awid", 32'(awid), 32'(id));
          chk(awaddr == addr, "R2", "awaddr", awaddr, addr);
          chk(awlen == 4'(n - 1), "R2", "awlen", 32'(awlen), 32'(n - 1));
          if (aw_wait == astall) begin
            awready = 1'b1; aw_done = 1; hs_t = t; last_end = t;
          end else begin
            awready = 1'b0; aw_wait++;
          end
        end else begin
          awready = 1'b0;
        end
      end else begin
        chk(awvalid == 1'b0, "R4", "awvalid after handshake", 32'(awvalid), 32'd0);
        awready = 1'b0;
      end

      // Response channel
      chk(bready == (k0 == n && !b_done), early_b ? "R12" : "R9", "bready",
          32'(bready), 32'(k0 == n && !b_done));
      if (!b_done) begin
        bid   = id;
        bresp = code;
        if (early_b) begin
          bvalid = 1'b1;
        end else if (k0 == n) begin
          bvalid = (b_cnt >= bdly);
          b_cnt++;
        end
        if (bvalid && bready) begin
          b_done = 1;
          rsp_t  = t + 1;
        end
      end

      chk(rsp_valid == (t == rsp_t), "R9", "rsp_valid strobe", 32'(rsp_valid), 32'(t == rsp_t));
      chk(cmd_ready == (t == rsp_t), "R10", "cmd_ready during burst", 32'(cmd_ready), 32'(t == rsp_t));
      if (t == rsp_t) begin
        chk(rsp_id == id, "R9", "rsp_id", 32'(rsp_id), 32'(id));
        chk(rsp_code == code, "R9", "rsp_code", 32'(rsp_code), 32'(code));
        done = 1;
      end
      @(negedge clk);
    end
    if (!done) chk(1'b0, "R9", "burst never finished", 32'd0, 32'd1);
    chk(rsp_valid == 1'b0, "R9", "strobe lasts one cycle", 32'(rsp_valid), 32'd0);
    bvalid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_id = '0; cmd_addr = '0; cmd_last_idx = '0;
    cmd_gap = '0; bm_we = 1'b0; bm_idx = '0; bm_data = '0; bm_gap = '0;
    awready = 1'b0; wready = 1'b0; bid = '0; bresp = '0; bvalid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk(awvalid == 1'b0, "R1", "awvalid after reset", 32'(awvalid), 32'd0);
    chk(wvalid == 1'b0, "R1", "wvalid after reset", 32'(wvalid), 32'd0);
    chk(bready == 1'b0, "R1", "bready after reset", 32'(bready), 32'd0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", 32'(cmd_ready), 32'd1);

    // Sweep all lengths with mixed gaps and stalls
    for (int n = 1; n <= 16; n++) begin
      run_burst(n, n, (n % 3 == 0) ? 0 : n % 4, n % 3, n % 2, (n % 5 == 0), (n % 4 == 1 && n > 1));
    end
    // Sweep again with no address gap or stalls
    for (int n = 1; n <= 16; n++) begin
      run_burst(n + 20, n, 0, 0, 0, 1'b0, 1'b0);
    end

    // R1: reset in the middle of a stalled address phase
    @(negedge clk);
    bm_we = 1'b1; bm_idx = 4'd0; bm_data = 32'hCAFE_0001; bm_gap = 8'd0;
    @(negedge clk);
    bm_we = 1'b0; cmd_valid = 1'b1; cmd_id = 4'd9; cmd_addr = 32'h2000_0000;
    cmd_last_idx = 4'd0; cmd_gap = 8'd0; awready = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(awvalid == 1'b1, "R4", "awvalid held while stalled", 32'(awvalid), 32'd1);
    rst_n = 1'b0;
    #1;
    chk(awvalid == 1'b0, "R1", "awvalid in mid-burst reset", 32'(awvalid), 32'd0);
    chk(cmd_ready == 1'b1, "R1", "cmd_ready in mid-burst reset", 32'(cmd_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(awvalid == 1'b0, "R1", "awvalid after mid-burst reset", 32'(awvalid), 32'd0);
    chk(cmd_ready == 1'b1, "R1", "cmd_ready after mid-burst reset", 32'(cmd_ready), 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule